// File: doc/BRIEF.md
# Quad-Channel Serial Converter Register Front End

This block is the digital front end of a four-channel 12-bit converter. A host shifts 16-bit words in over a three-wire serial port: a serial data line, a serial clock and an active-low select. A separate active-low load strobe moves the 12-bit data field of the received word into one of four channel registers. The register is chosen by a 2-bit address at the head of the word. The four register values are driven out in parallel to the converter cores.

An active-low clear forces every channel to zero or to midscale. The choice between the two follows a clear-select line. All external lines are sampled in one fast system clock. The serial clock and the select are combined by a logical OR, and a rising edge of that combination shifts one bit. A select that rises while the serial clock is low therefore injects an extra bit. A debug counter exposes how many bits have been shifted since select last fell, so software or tests can spot that hazard.

Top module: `qdac_front`

## Requirements
- R1: A word is 16 bits, sent first to last as the address MSB, the address LSB, two ignored bits, then data bits 11 down to 0. Address values 0, 1, 2 and 3 select channels 0, 1, 2 and 3. Channel k appears on `chan_q[12k+11:12k]`.
- R2: Every rising edge of (`sclk` OR `sel_n`) shifts one bit from `sdata` into the word. A rising `sel_n` while `sclk` is low shifts one extra bit.
- R3: While `sel_n` is high and `sclk` toggles, or while `sclk` is high and `sel_n` toggles, the word does not change.
- R4: While `ld_n` is low, the addressed channel takes the data field of the word, whatever the level of `sel_n`.
- R5: While `ld_n` stays low, the addressed channel keeps following the word as new bits arrive, with no further strobe.
- R6: While `clr_n` is low, every channel output reads 0x800 if `clr_mid` is 1 and 0x000 if it is 0. The outputs change at once, without waiting for a clock edge, and the channel registers take the same value.
- R7: Clear leaves the received word untouched. A load strobe after a clear writes the word that was present before the clear.
- R8: With `clr_n` and `ld_n` both high, every channel holds its value, including the clear value after a clear ends.
- R9: When clear and load are active together, the clear value wins on every channel.
- R10: `bit_cnt` goes to 0 when `sel_n` falls. It then rises by one for each shifted bit and saturates at 31.
- R11: After system reset, all channels read 0 and `bit_cnt` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous system reset |
| sclk | input | 1 | Serial clock |
| sdata | input | 1 | Serial data |
| sel_n | input | 1 | Active-low serial select |
| ld_n | input | 1 | Active-low load strobe, level sensitive |
| clr_n | input | 1 | Active-low clear |
| clr_mid | input | 1 | Clear value select: 1 gives midscale, 0 gives zero |
| chan_q | output | 48 | Four 12-bit channel values, channel 0 in the low bits |
| bit_cnt | output | 5 | Bits shifted since select last fell, saturating |

## Verification
The checker tests several rules on every cycle. The word moves only on a rise of the combined shift clock, and then by exactly one position. The counter only steps up by one or returns to zero. The channel bank holds whenever clear and load are both idle, and it takes the clear value after any cycle with clear active. Some behaviours only the bench scenarios can show: that each address reaches its own channel, that a late select rise injects a bit whose effect reaches the decoded address and data, that the clear override reaches the outputs before any clock edge, that the pre-clear word survives for a later load, and that a held-low load tracks a whole new word.

// File: rtl/qdac_front.sv
module qdac_front #(
  parameter int DW  = 12,
  parameter int NCH = 4,
  parameter int FW  = 16,
  parameter int CW  = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk,
  input  logic               sdata,
  input  logic               sel_n,
  input  logic               ld_n,
  input  logic               clr_n,
  input  logic               clr_mid,
  output logic [NCH*DW-1:0]  chan_q,
  output logic [CW-1:0]      bit_cnt
);
  localparam int            AW   = $clog2(NCH);
  localparam logic [DW-1:0] MID  = {1'b1, {(DW-1){1'b0}}};
  localparam logic [CW-1:0] CMAX = '1;
  localparam logic [5:0]    IDLE = 6'b011101;

  // sample order: {clr_mid, clr_n, ld_n, sel_n, sdata, sclk}
  logic [5:0] raw, s1, s2;
  assign raw = {clr_mid, clr_n, ld_n, sel_n, sdata, sclk};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= IDLE;
      s2 <= IDLE;
    end else begin
      s1 <= raw;
      s2 <= s1;
    end

  logic sck_now, sck_old, sel_old, shift_edge, sel_fall;
  logic clr_s, mid_s, ld_s;
  assign sck_now    = s2[0] | s2[2];
  assign shift_edge = sck_now & ~sck_old;
  assign sel_fall   = sel_old & ~s2[2];
  assign ld_s       = s2[3];
  assign clr_s      = s2[4];
  assign mid_s      = s2[5];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_old <= 1'b1;
      sel_old <= 1'b1;
    end else begin
      sck_old <= sck_now;
      sel_old <= s2[2];
    end

  logic [FW-1:0] sr;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          sr <= '0;
    else if (shift_edge) sr <= {sr[FW-2:0], s2[1]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                          bit_cnt <= '0;
    else if (sel_fall)                   bit_cnt <= '0;
    else if (shift_edge && bit_cnt != CMAX) bit_cnt <= bit_cnt + 1'b1;

  logic [AW-1:0] addr;
  logic [DW-1:0] clr_val;
  logic [NCH-1:0][DW-1:0] bank;
  assign addr    = sr[FW-1 -: AW];
  assign clr_val = mid_s ? MID : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      bank <= '0;
    else if (!clr_s) bank <= {NCH{clr_val}};
    else if (!ld_s)  bank[addr] <= sr[DW-1:0];

  for (genvar k = 0; k < NCH; k++) begin : g_out
    assign chan_q[k*DW +: DW] = clr_n ? bank[k] : (clr_mid ? MID : '0);
  end
endmodule

module qdac_front_chk #(
  parameter int DW  = 12,
  parameter int NCH = 4,
  parameter int FW  = 16,
  parameter int CW  = 5
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  shift_edge,
  input logic                  clr_s,
  input logic                  mid_s,
  input logic                  ld_s,
  input logic [FW-1:0]         sr,
  input logic [CW-1:0]         bit_cnt,
  input logic [NCH-1:0][DW-1:0] bank
);
  localparam logic [DW-1:0] MID = {1'b1, {(DW-1){1'b0}}};

  // R3
  sr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_edge |=> $stable(sr));

  // R2
  sr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_edge |=> sr[FW-1:1] == $past(sr[FW-2:0]));

  // R10
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_cnt != $past(bit_cnt)) |-> (bit_cnt == $past(bit_cnt) + 1'b1 || bit_cnt == '0));

  // R9
  clr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_s |=> bank == {NCH{($past(mid_s) ? MID : {DW{1'b0}})}});

  // R8
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_s && ld_s) |=> $stable(bank));
endmodule

bind qdac_front qdac_front_chk #(.DW(DW), .NCH(NCH), .FW(FW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .shift_edge(shift_edge), .clr_s(clr_s),
  .mid_s(mid_s), .ld_s(ld_s), .sr(sr), .bit_cnt(bit_cnt), .bank(bank));

// File: tb/sim_qdac_front.sv
module sim_qdac_front;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b1, sdata = 1'b0, sel_n = 1'b1, ld_n = 1'b1, clr_n = 1'b1, clr_mid = 1'b0;
  logic [47:0] chan_q;
  logic [4:0]  bit_cnt;
  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  qdac_front u0 (.clk(clk), .rst_n(rst_n), .sclk(sclk), .sdata(sdata), .sel_n(sel_n),
                 .ld_n(ld_n), .clr_n(clr_n), .clr_mid(clr_mid), .chan_q(chan_q), .bit_cnt(bit_cnt));

  // reference model: sampled inputs pass a three-deep history before acting
  localparam logic [5:0] IDLE = 6'b011101;
  logic [5:0]  hist[$];
  logic [15:0] m_sr;
  logic [11:0] m_bank[4];
  int          m_cnt;

  function automatic logic [11:0] ch(int k);
    return chan_q[k*12 +: 12];
  endfunction

  task automatic check(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = {IDLE, IDLE, IDLE};
      m_sr = '0; m_cnt = 0;
      foreach (m_bank[k]) m_bank[k] = '0;
    end else begin
      logic [5:0] cur, old;
      logic cond_edge, cond_fall;
      hist.push_back({clr_mid, clr_n, ld_n, sel_n, sdata, sclk});
      cur = hist[hist.size()-3];
      old = hist[hist.size()-4];
      if (hist.size() > 8) void'(hist.pop_front());
      cond_edge = (cur[0] | cur[2]) & ~(old[0] | old[2]);
      cond_fall = old[2] & ~cur[2];
      if (!cur[4]) foreach (m_bank[k]) m_bank[k] = cur[5] ? 12'h800 : 12'h000;
      else if (!cur[3]) m_bank[m_sr[15:14]] = m_sr[11:0];
      if (cond_edge) m_sr = {m_sr[14:0], cur[1]};
      if (cond_fall) m_cnt = 0;
      else if (cond_edge && m_cnt < 31) m_cnt++;
      #1;
      for (int k = 0; k < 4; k++)
        check($sformatf("R4 R6 model channel %0d", k), ch(k),
              !clr_n ? (clr_mid ? 12'h800 : 12'h000) : m_bank[k]);
      check("R10 model count", bit_cnt, m_cnt);
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_bit(logic b);
    sclk = 1'b0; sdata = b; tick(3);
    sclk = 1'b1; tick(3);
  endtask

  task automatic frame(logic [15:0] w, bit late_sel);
    sel_n = 1'b0; tick(3);
    for (int i = 15; i >= 0; i--) put_bit(w[i]);
    if (late_sel) begin
      sclk = 1'b0; tick(3);
      sel_n = 1'b1; tick(4);
      sclk = 1'b1; tick(3);
    end else begin
      sel_n = 1'b1; tick(4);
    end
  endtask

  task automatic strobe();
    ld_n = 1'b0; tick(4);
    ld_n = 1'b1; tick(5);
  endtask

  initial begin
    logic [11:0] dv[4];
    tick(5);
    rst_n = 1'b1;
    tick(5);
    for (int k = 0; k < 4; k++) check("R11 reset channel", ch(k), 0);
    check("R11 reset count", bit_cnt, 0);

    for (int a = 0; a < 4; a++) begin
      dv[a] = 12'h1A5 + 12'(a) * 12'h2D3;
      frame({2'(a), 2'b10, dv[a]}, 1'b0);
      check("R10 count after word", bit_cnt, 16);
      strobe();
      check("R1 R4 decoded channel", ch(a), dv[a]);
    end

    sel_n = 1'b0; tick(5);
    check("R10 select fall clears count", bit_cnt, 0);
    strobe();
    check("R4 load with select low", ch(3), dv[3]);
    sel_n = 1'b1; tick(4);

    for (int i = 0; i < 5; i++) begin sdata = ~sdata; put_bit(sdata); end
    check("R3 clock toggles with select high", bit_cnt, 0);
    sclk = 1'b1;
    for (int i = 0; i < 3; i++) begin sel_n = 1'b0; tick(4); sel_n = 1'b1; tick(4); end
    check("R3 select toggles with clock high", bit_cnt, 0);
    strobe();
    check("R3 word unchanged", ch(3), dv[3]);

    frame(16'h48C3, 1'b1);
    check("R2 extra bit counted", bit_cnt, 17);
    strobe();
    check("R2 shifted word decode", ch(2), 12'h187);
    check("R2 intended channel untouched", ch(1), dv[1]);

    ld_n = 1'b0; tick(4);
    frame({2'b11, 2'b00, 12'hE2D}, 1'b0);
    tick(3);
    check("R5 transparent load", ch(3), 12'hE2D);
    ld_n = 1'b1; tick(5);

    clr_mid = 1'b1; clr_n = 1'b0; #1;
    for (int k = 0; k < 4; k++) check("R6 immediate midscale", ch(k), 12'h800);
    tick(5);
    clr_n = 1'b1; tick(6);
    for (int k = 0; k < 4; k++) check("R8 clear value held", ch(k), 12'h800);
    strobe();
    check("R7 word kept through clear", ch(3), 12'hE2D);
    check("R7 other channel stays cleared", ch(0), 12'h800);
    clr_mid = 1'b0; clr_n = 1'b0; tick(4);
    for (int k = 0; k < 4; k++) check("R6 zero clear", ch(k), 0);
    clr_n = 1'b1; tick(4);

    frame({2'b00, 2'b01, 12'h5A5}, 1'b0);
    clr_mid = 1'b1; clr_n = 1'b0; ld_n = 1'b0; tick(5);
    check("R9 clear beats load", ch(0), 12'h800);
    clr_n = 1'b1; ld_n = 1'b1; tick(6);
    check("R9 clear value after joint release", ch(0), 12'h800);

    sel_n = 1'b0; tick(3);
    for (int i = 0; i < 35; i++) put_bit(i[0]);
    check("R10 count saturates", bit_cnt, 31);
    sel_n = 1'b1; tick(5);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    fails++;
    tests++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule